// File: doc/BRIEF.md
# Serial EEPROM Status Register and Write-Protect Arbiter

This block keeps the status register of a small serial EEPROM and rules on every write that the host requests. A serial front end, which is not part of this block, decodes the host's opcodes into single-cycle strobes. There are strobes for setting and clearing the write-enable latch, for writing the status register with a data byte, and for starting an array write at a given byte address. The block also watches an active-low write-protect pin and a completion pulse from the internal programming timer.

Each request produces a one-cycle grant or deny pulse in the following cycle. A granted write marks the device busy until the timer reports completion. The status byte is always available for the front end to shift out. The nonvolatile copies of the protect fields enter through preload inputs that are sampled at reset. A parameter sizes the array at 1 KiB or 2 KiB, and the size sets where the protected regions begin.

Top module: `eeprom_wp_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is: latch 0, busy 0, protect code = `preload_bp`, pin-enable = `preload_pin_en`, and all four verdict outputs 0.
- R2: `status_byte` is packed as follows: bit 0 is 1 while busy, bit 1 is the write-enable latch, bits 3:2 are the protect code, bits 6:4 are always 0, and bit 7 is the pin-enable bit.
- R3: When idle, a write-enable strobe sets the latch and a write-disable strobe clears it. The new value is visible in the cycle after the strobe.
- R4: With the latch at 0, every status write and every array write is denied.
- R5: Protect code 00 covers no address. Code 01 covers the top quarter of the array (0x600–0x7FF at 2 KiB, 0x300–0x3FF at 1 KiB). Code 10 covers the top half. Code 11 covers the whole array. An array write to a covered address is always denied. An array write to an uncovered address is granted when the latch is 1.
- R6: Hardware protection is active when `wp_n` is 0 and the pin-enable bit is 1. While it is active, status writes are denied even with the latch set.
- R7: With the latch set and hardware protection inactive, a status write is granted.
- R8: A grant pulses in the cycle after the request, and `busy` (and status bit 0) rise in that same cycle. A granted status write loads `wrsr_data[7]` into pin-enable and `wrsr_data[3:2]` into the protect code. All other data bits are ignored.
- R9: A `wr_done` pulse while busy clears both busy and the latch in the next cycle. A `wr_done` pulse while idle has no effect.
- R10: A deny pulse comes with the latch cleared in the same cycle.
- R11: While busy, every command strobe is ignored: there is no verdict pulse, and neither the latch nor the protect fields change.
- R12: If several strobes arrive together, only one is acted on, in this priority order: status write, then array write, then write-disable, then write-enable. At most one verdict output pulses per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| preload_bp | input | 2 | Stored protect code loaded at reset |
| preload_pin_en | input | 1 | Stored pin-enable bit loaded at reset |
| cmd_wren | input | 1 | Set-latch strobe |
| cmd_wrdi | input | 1 | Clear-latch strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| wrsr_data | input | 8 | Data byte for the status write |
| cmd_arr_wr | input | 1 | Array-write strobe |
| arr_addr | input | ADDR_W | Byte address of the array write |
| wp_n | input | 1 | Write-protect pin, active low |
| wr_done | input | 1 | Internal programming cycle finished |
| status_byte | output | 8 | Status register contents |
| busy | output | 1 | Internal write in progress |
| sr_grant | output | 1 | Status write accepted |
| sr_deny | output | 1 | Status write refused |
| arr_grant | output | 1 | Array write accepted |
| arr_deny | output | 1 | Array write refused |

## Verification
The bench aims array writes at addresses on both sides of each region edge (0x5FF/0x600 and 0x3FF/0x400). A comparator that is off by one there would grant a write into protected space or refuse a legal one. It also requests status writes with the pin low, once with pin-enable set and once with it clear. A design that ignored pin-enable, or applied the pin to array writes, would give the wrong verdict. Strobes are issued during a busy cycle, where a design would otherwise clear the latch or rewrite the protect fields mid-program. Garbage is placed in the unused data bits, which a mis-sliced status write would latch. Random traffic then checks the latch's automatic clearing after completions and after denials against a bench model.

// File: rtl/eepst_pkg.sv
package eepst_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SET_LATCH,
        OP_CLR_LATCH,
        OP_STATUS_WR,
        OP_ARRAY_WR
    } op_e;

    typedef struct packed {
        logic       pin_en;
        logic [1:0] bp;
        logic       wel;
        logic       busy;
    } status_t;

    typedef struct packed {
        logic sr_grant;
        logic sr_deny;
        logic arr_grant;
        logic arr_deny;
    } verdict_t;

    typedef struct packed {
        logic       pin_en;
        logic [1:0] bp;
    } guard_t;

    function automatic logic [7:0] pack_status(status_t s);
        return {s.pin_en, 3'b000, s.bp, s.wel, s.busy};
    endfunction

    function automatic guard_t guard_from_byte(logic [7:0] d);
        guard_t g;
        g.pin_en = d[7];
        g.bp     = d[3:2];
        return g;
    endfunction

    // Regions always end at the top of the array, so the two highest address bits decide.
    function automatic logic addr_covered(logic [1:0] bp, logic [15:0] addr, int unsigned aw);
        logic hi1;
        logic hi0;
        hi1 = addr[aw-1];
        hi0 = addr[aw-2];
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return hi1 & hi0;
            2'b10:   return hi1;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/eepst_op_select.sv
module eepst_op_select
    import eepst_pkg::*;
(
    input  logic busy,
    input  logic cmd_wren,
    input  logic cmd_wrdi,
    input  logic cmd_wrsr,
    input  logic cmd_arr_wr,
    output op_e  op
);
    always_comb begin
        if (busy)            op = OP_NONE;
        else if (cmd_wrsr)   op = OP_STATUS_WR;
        else if (cmd_arr_wr) op = OP_ARRAY_WR;
        else if (cmd_wrdi)   op = OP_CLR_LATCH;
        else if (cmd_wren)   op = OP_SET_LATCH;
        else                 op = OP_NONE;
    end
endmodule

// File: rtl/eepst_region_chk.sv
module eepst_region_chk
    import eepst_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              covered
);
    logic [15:0] addr_ext;

    always_comb begin
        addr_ext = 16'(addr);
        covered  = addr_covered(bp, addr_ext, ADDR_W);
    end
endmodule

// File: rtl/eepst_judge.sv
module eepst_judge
    import eepst_pkg::*;
(
    input  op_e      op,
    input  status_t  st,
    input  logic     wp_n,
    input  logic     covered,
    output verdict_t vd
);
    logic hw_lock;

    always_comb begin
        hw_lock = ~wp_n & st.pin_en;
        vd      = '0;
        case (op)
            OP_STATUS_WR: begin
                vd.sr_grant = st.wel & ~hw_lock;
                vd.sr_deny  = ~vd.sr_grant;
            end
            OP_ARRAY_WR: begin
                vd.arr_grant = st.wel & ~covered;
                vd.arr_deny  = ~vd.arr_grant;
            end
            default: vd = '0;
        endcase
    end
endmodule

// File: rtl/eepst_state.sv
module eepst_state
    import eepst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] preload_bp,
    input  logic       preload_pin_en,
    input  op_e        op,
    input  verdict_t   vd,
    input  guard_t     new_guard,
    input  logic       wr_done,
    output status_t    st,
    output verdict_t   vd_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st.pin_en <= preload_pin_en;
            st.bp     <= preload_bp;
            st.wel    <= 1'b0;
            st.busy   <= 1'b0;
            vd_q      <= '0;
        end else begin
            vd_q <= vd;
            if (st.busy) begin
                if (wr_done) begin
                    st.busy <= 1'b0;
                    st.wel  <= 1'b0;
                end
            end else begin
                case (op)
                    OP_SET_LATCH: st.wel <= 1'b1;
                    OP_CLR_LATCH: st.wel <= 1'b0;
                    OP_STATUS_WR: begin
                        if (vd.sr_grant) begin
                            st.pin_en <= new_guard.pin_en;
                            st.bp     <= new_guard.bp;
                            st.busy   <= 1'b1;
                        end else begin
                            st.wel <= 1'b0;
                        end
                    end
                    OP_ARRAY_WR: begin
                        if (vd.arr_grant) st.busy <= 1'b1;
                        else              st.wel  <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/eeprom_wp_ctrl.sv
module eeprom_wp_ctrl
    import eepst_pkg::*;
#(
    parameter  int ARRAY_KB = 2,
    localparam int ADDR_W   = $clog2(ARRAY_KB * 1024)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        preload_bp,
    input  logic              preload_pin_en,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic [7:0]        wrsr_data,
    input  logic              cmd_arr_wr,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic              wp_n,
    input  logic              wr_done,
    output logic [7:0]        status_byte,
    output logic              busy,
    output logic              sr_grant,
    output logic              sr_deny,
    output logic              arr_grant,
    output logic              arr_deny
);
    op_e      op;
    status_t  st;
    verdict_t vd;
    verdict_t vd_q;
    guard_t   new_guard;
    logic     covered;

    assign new_guard = guard_from_byte(wrsr_data);

    eepst_op_select u_sel (
        .busy      (st.busy),
        .cmd_wren  (cmd_wren),
        .cmd_wrdi  (cmd_wrdi),
        .cmd_wrsr  (cmd_wrsr),
        .cmd_arr_wr(cmd_arr_wr),
        .op        (op)
    );

    eepst_region_chk #(.ADDR_W(ADDR_W)) u_region (
        .bp     (st.bp),
        .addr   (arr_addr),
        .covered(covered)
    );

    eepst_judge u_judge (
        .op     (op),
        .st     (st),
        .wp_n   (wp_n),
        .covered(covered),
        .vd     (vd)
    );

    eepst_state u_state (
        .clk           (clk),
        .rst           (rst),
        .preload_bp    (preload_bp),
        .preload_pin_en(preload_pin_en),
        .op            (op),
        .vd            (vd),
        .new_guard     (new_guard),
        .wr_done       (wr_done),
        .st            (st),
        .vd_q          (vd_q)
    );

    assign status_byte = pack_status(st);
    assign busy        = st.busy;
    assign sr_grant    = vd_q.sr_grant;
    assign sr_deny     = vd_q.sr_deny;
    assign arr_grant   = vd_q.arr_grant;
    assign arr_deny    = vd_q.arr_deny;
endmodule

// File: rtl/eepst_checker.sv
module eepst_checker (
    input logic       clk,
    input logic       rst,
    input logic       cmd_wren,
    input logic       cmd_wrdi,
    input logic       cmd_wrsr,
    input logic       cmd_arr_wr,
    input logic       wr_done,
    input logic [7:0] status_byte,
    input logic       busy,
    input logic       sr_grant,
    input logic       sr_deny,
    input logic       arr_grant,
    input logic       arr_deny
);
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        status_byte[6:4] == 3'b000);

    p_set_latch_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_wren && !cmd_wrdi && !cmd_wrsr && !cmd_arr_wr) |=> status_byte[1]);

    p_clr_latch_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_wrdi && !cmd_wrsr && !cmd_arr_wr) |=> !status_byte[1]);

    p_sr_no_latch_r4: assert property (@(posedge clk) disable iff (rst)
        (!busy && !status_byte[1] && cmd_wrsr) |=> sr_deny);

    p_arr_no_latch_r4: assert property (@(posedge clk) disable iff (rst)
        (!busy && !status_byte[1] && cmd_arr_wr && !cmd_wrsr) |=> arr_deny);

    p_grant_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (sr_grant || arr_grant) |-> busy);

    p_done_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_done) |=> (!busy && !status_byte[1]));

    p_deny_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (sr_deny || arr_deny) |-> !status_byte[1]);

    p_busy_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        busy |=> !(sr_grant || sr_deny || arr_grant || arr_deny));

    p_guard_by_grant_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable({status_byte[7], status_byte[3:2]})) |-> sr_grant);

    p_one_verdict_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sr_grant, sr_deny, arr_grant, arr_deny}));
endmodule

bind eeprom_wp_ctrl eepst_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_wren   (cmd_wren),
    .cmd_wrdi   (cmd_wrdi),
    .cmd_wrsr   (cmd_wrsr),
    .cmd_arr_wr (cmd_arr_wr),
    .wr_done    (wr_done),
    .status_byte(status_byte),
    .busy       (busy),
    .sr_grant   (sr_grant),
    .sr_deny    (sr_deny),
    .arr_grant  (arr_grant),
    .arr_deny   (arr_deny)
);

// File: tb/test_eeprom_wp_ctrl.sv
module test_eeprom_wp_ctrl;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    preload_bp = 2'b00;
    logic          preload_pin_en = 1'b0;
    logic          cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_wrsr = 1'b0, cmd_arr_wr = 1'b0;
    logic [7:0]    wrsr_data = 8'h00;
    logic [AW-1:0] arr_addr = '0;
    logic          wp_n = 1'b1;
    logic          wr_done = 1'b0;
    logic [7:0]    status_byte;
    logic          busy, sr_grant, sr_deny, arr_grant, arr_deny;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // bench model
    bit m_wel, m_busy, m_pen;
    bit [1:0] m_bp;
    bit e_sg, e_sd, e_ag, e_ad;

    always #4 clk = ~clk;

    eeprom_wp_ctrl #(.ARRAY_KB(2)) i_eeprom_wp_ctrl (
        .clk(clk), .rst(rst), .preload_bp(preload_bp), .preload_pin_en(preload_pin_en),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data),
        .cmd_arr_wr(cmd_arr_wr), .arr_addr(arr_addr), .wp_n(wp_n), .wr_done(wr_done),
        .status_byte(status_byte), .busy(busy), .sr_grant(sr_grant), .sr_deny(sr_deny),
        .arr_grant(arr_grant), .arr_deny(arr_deny)
    );

    function automatic bit in_region(bit [1:0] bp, int unsigned a);
        int unsigned size;
        size = 1 << AW;
        case (bp)
            2'd0: return 1'b0;
            2'd1: return a >= size - size / 4;
            2'd2: return a >= size / 2;
            default: return 1'b1;
        endcase
    endfunction

    function automatic bit [7:0] exp_status();
        return {m_pen, 3'b000, m_bp, m_wel, m_busy};
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    task automatic compare_all();
        chk("R2 status byte", status_byte, exp_status());
        chk("R8 busy", {7'd0, busy}, {7'd0, m_busy});
        chk("R7 status verdict", {6'd0, sr_grant, sr_deny}, {6'd0, e_sg, e_sd});
        chk("R5 array verdict", {6'd0, arr_grant, arr_deny}, {6'd0, e_ag, e_ad});
    endtask

    task automatic do_reset(input bit [1:0] bp, input bit pen);
        @(negedge clk);
        rst = 1'b1; preload_bp = bp; preload_pin_en = pen;
        cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_arr_wr = 0; wr_done = 0;
        @(posedge clk); @(negedge clk);
        m_wel = 0; m_busy = 0; m_bp = bp; m_pen = pen;
        e_sg = 0; e_sd = 0; e_ag = 0; e_ad = 0;
        chk("R1 reset status", status_byte, {pen, 3'b000, bp, 2'b00});
        chk("R1 reset verdicts", {3'd0, busy, sr_grant, sr_deny, arr_grant, arr_deny}, 8'h00);
        rst = 1'b0;
    endtask

    // Called at a negedge: drive, advance one cycle, update model, compare.
    task automatic step(input bit wen, input bit wdi, input bit wsr, input bit awr,
                        input bit [7:0] d, input bit [AW-1:0] a, input bit pin, input bit dn);
        bit lock;
        cmd_wren = wen; cmd_wrdi = wdi; cmd_wrsr = wsr; cmd_arr_wr = awr;
        wrsr_data = d; arr_addr = a; wp_n = pin; wr_done = dn;
        e_sg = 0; e_sd = 0; e_ag = 0; e_ad = 0;
        lock = !pin && m_pen;
        if (m_busy) begin
            if (dn) begin m_busy = 0; m_wel = 0; end
        end else if (wsr) begin
            if (m_wel && !lock) begin
                e_sg = 1; m_pen = d[7]; m_bp = d[3:2]; m_busy = 1;
            end else begin
                e_sd = 1; m_wel = 0;
            end
        end else if (awr) begin
            if (m_wel && !in_region(m_bp, a)) begin e_ag = 1; m_busy = 1; end
            else begin e_ad = 1; m_wel = 0; end
        end else if (wdi) m_wel = 0;
        else if (wen) m_wel = 1;
        @(posedge clk); @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input bit dn);
        step(0, 0, 0, 0, 8'h00, '0, 1'b1, dn);
    endtask

    initial begin
        m_wel = 0; m_busy = 0; m_pen = 0; m_bp = 0;
        void'($urandom(32'd20240611));
        do_reset(2'b00, 1'b0);

        // R3 latch set / clear
        step(1, 0, 0, 0, 8'h00, '0, 1, 0);
        chk("R3 latch set", {7'd0, status_byte[1]}, 8'd1);
        step(0, 1, 0, 0, 8'h00, '0, 1, 0);
        chk("R3 latch clear", {7'd0, status_byte[1]}, 8'd0);

        // R4 no latch -> deny both kinds
        step(0, 0, 0, 1, 8'h00, 11'h010, 1, 0);
        chk("R4 array deny", {7'd0, arr_deny}, 8'd1);
        step(0, 0, 1, 0, 8'h8C, '0, 1, 0);
        chk("R4 status deny", {7'd0, sr_deny}, 8'd1);

        // R8 status write, garbage in unused bits: 0xF7 -> pen=1, bp=01
        step(1, 0, 0, 0, 8'h00, '0, 1, 0);
        step(0, 0, 1, 0, 8'hF7, '0, 1, 0);
        chk("R8 status loaded", status_byte, 8'h87);
        // R11 strobes while busy are ignored
        step(0, 1, 0, 0, 8'h00, '0, 1, 0);
        chk("R11 latch held while busy", {7'd0, status_byte[1]}, 8'd1);
        step(0, 0, 1, 0, 8'h00, '0, 1, 0);
        chk("R11 no verdict while busy", {4'd0, sr_grant, sr_deny, arr_grant, arr_deny}, 8'h00);
        chk("R11 fields held while busy", status_byte, 8'h87);
        // R9 completion
        idle(1);
        chk("R9 done clears", status_byte, 8'h84);
        idle(1);
        chk("R9 done while idle ignored", status_byte, 8'h84);

        // R5 quarter boundary
        step(1, 0, 0, 0, 8'h00, '0, 1, 0);
        step(0, 0, 0, 1, 8'h00, 11'h5FF, 1, 0);
        chk("R5 0x5FF granted", {7'd0, arr_grant}, 8'd1);
        idle(1);
        step(1, 0, 0, 0, 8'h00, '0, 1, 0);
        step(0, 0, 0, 1, 8'h00, 11'h600, 1, 0);
        chk("R5 0x600 denied", {7'd0, arr_deny}, 8'd1);
        chk("R10 deny clears latch", {7'd0, status_byte[1]}, 8'd0);

        // R6 pin low with pin-enable set
        step(1, 0, 0, 0, 8'h00, '0, 0, 0);
        step(0, 0, 1, 0, 8'h00, '0, 0, 0);
        chk("R6 status write locked", {7'd0, sr_deny}, 8'd1);
        step(1, 0, 0, 0, 8'h00, '0, 0, 0);
        step(0, 0, 0, 1, 8'h00, 11'h100, 0, 0);
        chk("R6 unprotected array write", {7'd0, arr_grant}, 8'd1);
        idle(1);

        // R7 pin low but pin-enable cleared via status write first
        step(1, 0, 0, 0, 8'h00, '0, 1, 0);
        step(0, 0, 1, 0, 8'h08, '0, 1, 0);
        idle(1);
        step(1, 0, 0, 0, 8'h00, '0, 0, 0);
        step(0, 0, 1, 0, 8'h00, '0, 0, 0);
        chk("R7 granted with pin-enable 0", {7'd0, sr_grant}, 8'd1);
        idle(1);

        // R12 priority
        step(1, 1, 0, 0, 8'h00, '0, 1, 0);
        chk("R12 clear beats set", {7'd0, status_byte[1]}, 8'd0);
        step(1, 0, 1, 1, 8'h00, 11'h000, 1, 0);
        chk("R12 status write wins", {6'd0, sr_deny, arr_deny}, 8'h02);

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            bit [AW-1:0] a;
            r = $urandom % 16;
            case ($urandom % 4)
                0: a = 11'h5FF + AW'($urandom % 3);
                1: a = 11'h3FF + AW'($urandom % 3);
                default: a = AW'($urandom);
            endcase
            step(r < 4, r == 4, r == 5 || r == 6, r >= 7 && r <= 10,
                 8'($urandom), a, 1'($urandom), ($urandom % 4) == 0);
        end

        do_reset(2'b11, 1'b1);
        for (int i = 0; i < 500; i++) begin
            int unsigned r;
            r = $urandom % 16;
            step(r < 5, r == 5, r == 6 || r == 7, r >= 8 && r <= 11,
                 8'($urandom), AW'($urandom), 1'($urandom), ($urandom % 3) == 0);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion at cycle %0d", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule